// File: doc/BRIEF.md
# Page Migration Sequencing Controller

This block is the central sequencer that moves one memory page from a source compute module to a destination compute module, in a system of a fixed number of modules. It accepts one migration job at a time, and only while the periodic migration window is open. A job carries a page id, a source module id, a destination module id and the free frame reserved at the destination. The controller then runs the job through three stages: prepare, process and finalize.

In the prepare stage the controller broadcasts a page-lock message. On that message every module writes the page back to memory and blocks access to it. The controller stays in prepare until every module has returned a lock acknowledgement. In the process stage it sends a move command to the source module and a store command to the destination module. It then waits for the destination to report that the page and its flags are stored. In the finalize stage it broadcasts a resume message that carries the page id and the new frame, and it pulses done once that broadcast is taken.

The copying itself is done by external agents, which exchange valid/ready handshakes with this controller. The policy that chooses which page to move is also outside the block.

The state machine has seven states:

| State | Leaves when | Goes to |
|---|---|---|
| IDLE | a request handshake is made while the window is open | LOCK_SEND |
| LOCK_SEND | the lock broadcast is accepted | LOCK_WAIT |
| LOCK_WAIT | the ack mask is all ones | ISSUE |
| ISSUE | both the move and the store command are accepted | XFER_WAIT |
| XFER_WAIT | completion arrives | RESUME_SEND |
| RESUME_SEND | the resume broadcast is accepted | DONE |
| DONE | unconditionally, after one cycle | IDLE |

Top module: `pgmig_seq`

## Requirements
- R1: During reset and just after it, lock_valid, move_valid, store_valid, resume_valid and done are all 0, and req_ready equals phase_open.
- R2: req_ready is 1 only in IDLE and only while phase_open is 1. A request offered while the window is closed, or while a job is in progress, is not taken and leaves the running job's fields unchanged.
- R3: The cycle after a request is accepted, lock_valid rises with lock_page equal to the request's page id. Both hold until lock_ready is 1.
- R4: Bit i of lock_ack acknowledges module i and sets bit i of an internal mask. Repeated acks from the same module add nothing. Move and store commands appear two cycles after the cycle in which the last missing module acks.
- R5: Acks that arrive before the lock broadcast is accepted, or in the same cycle as that acceptance, are ignored.
- R6: After preparation, the move command goes out with move_mod equal to the source id, and move_peer, move_page and move_frame set from the job. The store command goes out with store_mod equal to the destination id, and store_peer, store_page and store_frame set from the job. Each command holds until its own ready, and the two may be accepted in either order or in the same cycle.
- R7: resume_valid rises only in the cycle after cmpl_valid is seen in XFER_WAIT. A completion pulse that arrives while either command is still pending is ignored.
- R8: The resume broadcast carries the job's page and frame, and it holds until resume_ready is 1.
- R9: done is 1 for exactly the one cycle after the resume handshake. In the cycle after that, the block is in IDLE and req_ready follows phase_open again.
- R10: A second job starts with an empty ack mask and carries only its own fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_open | input | 1 | Migration window is open |
| req_valid | input | 1 | Migration job offered |
| req_ready | output | 1 | Job can be accepted |
| req_page | input | PAGE_W | Page id |
| req_src | input | MOD_W | Source module id |
| req_dst | input | MOD_W | Destination module id |
| req_frame | input | FRAME_W | Free destination frame |
| lock_valid | output | 1 | Page-lock broadcast valid |
| lock_ready | input | 1 | Page-lock broadcast taken |
| lock_page | output | PAGE_W | Page to lock |
| lock_ack | input | N_MODS | Per-module lock-complete acks |
| move_valid | output | 1 | Move command to source valid |
| move_ready | input | 1 | Move command taken |
| move_mod | output | MOD_W | Addressed (source) module |
| move_peer | output | MOD_W | Destination of the data |
| move_page | output | PAGE_W | Page to move |
| move_frame | output | FRAME_W | Target frame |
| store_valid | output | 1 | Store command to destination valid |
| store_ready | input | 1 | Store command taken |
| store_mod | output | MOD_W | Addressed (destination) module |
| store_peer | output | MOD_W | Module the data comes from |
| store_page | output | PAGE_W | Page to store |
| store_frame | output | FRAME_W | Frame to store into |
| cmpl_valid | input | 1 | Destination reports store complete |
| resume_valid | output | 1 | Resume broadcast valid |
| resume_ready | input | 1 | Resume broadcast taken |
| resume_page | output | PAGE_W | Migrated page |
| resume_frame | output | FRAME_W | New physical frame |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The ack gate is exercised with three patterns. All modules acking at once checks the two-cycle advance. Acks in a scattered order with repeats, leaving one module missing, separate a true per-module mask from an ack counter. Acks sent before the lock broadcast is taken separate a gated mask from one that is always open. The command pair is accepted both in the same cycle and one after the other, with a completion pulse injected between them; this shows that completion is honoured only once both commands have left. Resume stalls, a closed window and a request offered while busy confirm that data holds under back-pressure and that admission is gated. A second job with different ids confirms that the mask and the fields are reloaded.

// File: rtl/pgmig_pkg.sv
package pgmig_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCK_SEND,
        ST_LOCK_WAIT,
        ST_ISSUE,
        ST_XFER_WAIT,
        ST_RESUME_SEND,
        ST_DONE
    } mig_state_e;

    localparam int unsigned NUM_CMD  = 2;
    localparam int unsigned CMD_MOVE  = 0;
    localparam int unsigned CMD_STORE = 1;

endpackage

// File: rtl/pgmig_ack_mask.sv
module pgmig_ack_mask #(
    parameter int unsigned N_MODS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic [N_MODS-1:0] ack_i,
    output logic [N_MODS-1:0] mask_o,
    output logic              all_o
);

    logic [N_MODS-1:0] mask_q;

    for (genvar i = 0; i < N_MODS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[i] <= 1'b0;
            end else if (clr_i) begin
                mask_q[i] <= 1'b0;
            end else if (en_i && ack_i[i]) begin
                mask_q[i] <= 1'b1;
            end
        end
    end

    assign mask_o = mask_q;
    assign all_o  = &mask_q;

    // Bits only ever set between clears (R4)
    assert_mask_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((mask_o & $past(mask_o)) == $past(mask_o)));

    // Acks outside the wait window leave the mask untouched (R5)
    assert_mask_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(mask_o));

endmodule

// File: rtl/pgmig_pair_issue.sv
module pgmig_pair_issue #(
    parameter int unsigned N_CMD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [N_CMD-1:0] rdy_i,
    output logic [N_CMD-1:0] vld_o,
    output logic             all_done_o
);

    logic [N_CMD-1:0] sent_q;
    logic [N_CMD-1:0] fin;

    for (genvar c = 0; c < N_CMD; c++) begin : g_cmd
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sent_q[c] <= 1'b0;
            end else if (!active_i) begin
                sent_q[c] <= 1'b0;
            end else if (vld_o[c] && rdy_i[c]) begin
                sent_q[c] <= 1'b1;
            end
        end

        assign vld_o[c] = active_i && !sent_q[c];
        assign fin[c]   = sent_q[c] || (vld_o[c] && rdy_i[c]);

        // A command held back stays offered (R6)
        assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_o[c] && !rdy_i[c]) |=> vld_o[c]);
    end

    assign all_done_o = active_i && (&fin);

endmodule

// File: rtl/pgmig_fsm.sv
module pgmig_fsm
    import pgmig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic phase_open_i,
    input  logic req_valid_i,
    input  logic lock_ready_i,
    input  logic mask_all_i,
    input  logic pair_done_i,
    input  logic cmpl_valid_i,
    input  logic resume_ready_i,
    output logic req_ready_o,
    output logic lock_valid_o,
    output logic mask_clr_o,
    output logic mask_en_o,
    output logic issue_active_o,
    output logic resume_valid_o,
    output logic done_o
);

    mig_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (phase_open_i && req_valid_i) state_d = ST_LOCK_SEND;
            ST_LOCK_SEND:   if (lock_ready_i)                state_d = ST_LOCK_WAIT;
            ST_LOCK_WAIT:   if (mask_all_i)                  state_d = ST_ISSUE;
            ST_ISSUE:       if (pair_done_i)                 state_d = ST_XFER_WAIT;
            ST_XFER_WAIT:   if (cmpl_valid_i)                state_d = ST_RESUME_SEND;
            ST_RESUME_SEND: if (resume_ready_i)              state_d = ST_DONE;
            ST_DONE:                                         state_d = ST_IDLE;
            default:                                         state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready_o    = (state_q == ST_IDLE) && phase_open_i;
        lock_valid_o   = (state_q == ST_LOCK_SEND);
        mask_clr_o     = (state_q == ST_LOCK_SEND) && lock_ready_i;
        mask_en_o      = (state_q == ST_LOCK_WAIT);
        issue_active_o = (state_q == ST_ISSUE);
        resume_valid_o = (state_q == ST_RESUME_SEND);
        done_o         = (state_q == ST_DONE);
    end

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(resume_valid_o && resume_ready_i));

endmodule

// File: rtl/pgmig_seq.sv
module pgmig_seq
    import pgmig_pkg::*;
#(
    parameter int unsigned N_MODS  = 4,
    parameter int unsigned PAGE_W  = 20,
    parameter int unsigned FRAME_W = 24,
    localparam int unsigned MOD_W  = (N_MODS > 1) ? $clog2(N_MODS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phase_open,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [PAGE_W-1:0]  req_page,
    input  logic [MOD_W-1:0]   req_src,
    input  logic [MOD_W-1:0]   req_dst,
    input  logic [FRAME_W-1:0] req_frame,
    output logic               lock_valid,
    input  logic               lock_ready,
    output logic [PAGE_W-1:0]  lock_page,
    input  logic [N_MODS-1:0]  lock_ack,
    output logic               move_valid,
    input  logic               move_ready,
    output logic [MOD_W-1:0]   move_mod,
    output logic [MOD_W-1:0]   move_peer,
    output logic [PAGE_W-1:0]  move_page,
    output logic [FRAME_W-1:0] move_frame,
    output logic               store_valid,
    input  logic               store_ready,
    output logic [MOD_W-1:0]   store_mod,
    output logic [MOD_W-1:0]   store_peer,
    output logic [PAGE_W-1:0]  store_page,
    output logic [FRAME_W-1:0] store_frame,
    input  logic               cmpl_valid,
    output logic               resume_valid,
    input  logic               resume_ready,
    output logic [PAGE_W-1:0]  resume_page,
    output logic [FRAME_W-1:0] resume_frame,
    output logic               done
);

    typedef struct packed {
        logic [PAGE_W-1:0]  page;
        logic [MOD_W-1:0]   src;
        logic [MOD_W-1:0]   dst;
        logic [FRAME_W-1:0] frame;
    } job_t;

    job_t              job_q;
    logic              mask_clr, mask_en, mask_all, issue_active, pair_done;
    logic [N_MODS-1:0] ack_mask;
    logic [NUM_CMD-1:0] cmd_rdy, cmd_vld;

    pgmig_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .phase_open_i   (phase_open),
        .req_valid_i    (req_valid),
        .lock_ready_i   (lock_ready),
        .mask_all_i     (mask_all),
        .pair_done_i    (pair_done),
        .cmpl_valid_i   (cmpl_valid),
        .resume_ready_i (resume_ready),
        .req_ready_o    (req_ready),
        .lock_valid_o   (lock_valid),
        .mask_clr_o     (mask_clr),
        .mask_en_o      (mask_en),
        .issue_active_o (issue_active),
        .resume_valid_o (resume_valid),
        .done_o         (done)
    );

    pgmig_ack_mask #(.N_MODS(N_MODS)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (mask_clr),
        .en_i   (mask_en),
        .ack_i  (lock_ack),
        .mask_o (ack_mask),
        .all_o  (mask_all)
    );

    assign cmd_rdy[CMD_MOVE]  = move_ready;
    assign cmd_rdy[CMD_STORE] = store_ready;

    pgmig_pair_issue #(.N_CMD(NUM_CMD)) u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (issue_active),
        .rdy_i      (cmd_rdy),
        .vld_o      (cmd_vld),
        .all_done_o (pair_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job_q <= '0;
        end else if (req_valid && req_ready) begin
            job_q <= '{page: req_page, src: req_src, dst: req_dst, frame: req_frame};
        end
    end

    assign lock_page    = job_q.page;
    assign move_valid   = cmd_vld[CMD_MOVE];
    assign move_mod     = job_q.src;
    assign move_peer    = job_q.dst;
    assign move_page    = job_q.page;
    assign move_frame   = job_q.frame;
    assign store_valid  = cmd_vld[CMD_STORE];
    assign store_mod    = job_q.dst;
    assign store_peer   = job_q.src;
    assign store_page   = job_q.page;
    assign store_frame  = job_q.frame;
    assign resume_page  = job_q.page;
    assign resume_frame = job_q.frame;

    assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_valid && !lock_ready) |=> (lock_valid && $stable(lock_page)));

    assert_issue_needs_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (move_valid || store_valid) |-> (ack_mask == {N_MODS{1'b1}}));

    assert_resume_after_cmpl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_valid) |-> $past(cmpl_valid));

    assert_resume_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_valid && !resume_ready) |=> (resume_valid && $stable(resume_frame)));

endmodule

// File: tb/pgmig_seq_tb_top.sv
`timescale 1ns/1ps
module pgmig_seq_tb_top;

    localparam int N = 4;
    localparam int PW = 20;
    localparam int FW = 24;
    localparam int MW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic phase_open = 1'b0, req_valid = 1'b0, lock_ready = 1'b0;
    logic move_ready = 1'b0, store_ready = 1'b0, cmpl_valid = 1'b0, resume_ready = 1'b0;
    logic [PW-1:0] req_page = '0;
    logic [MW-1:0] req_src = '0, req_dst = '0;
    logic [FW-1:0] req_frame = '0;
    logic [N-1:0]  lock_ack = '0;
    logic req_ready, lock_valid, move_valid, store_valid, resume_valid, done;
    logic [PW-1:0] lock_page, move_page, store_page, resume_page;
    logic [MW-1:0] move_mod, move_peer, store_mod, store_peer;
    logic [FW-1:0] move_frame, store_frame, resume_frame;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pgmig_seq #(.N_MODS(N), .PAGE_W(PW), .FRAME_W(FW)) dut_i (
        .clk(clk), .rst_n(rst_n), .phase_open(phase_open),
        .req_valid(req_valid), .req_ready(req_ready), .req_page(req_page),
        .req_src(req_src), .req_dst(req_dst), .req_frame(req_frame),
        .lock_valid(lock_valid), .lock_ready(lock_ready), .lock_page(lock_page),
        .lock_ack(lock_ack),
        .move_valid(move_valid), .move_ready(move_ready), .move_mod(move_mod),
        .move_peer(move_peer), .move_page(move_page), .move_frame(move_frame),
        .store_valid(store_valid), .store_ready(store_ready), .store_mod(store_mod),
        .store_peer(store_peer), .store_page(store_page), .store_frame(store_frame),
        .cmpl_valid(cmpl_valid),
        .resume_valid(resume_valid), .resume_ready(resume_ready),
        .resume_page(resume_page), .resume_frame(resume_frame), .done(done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= 100000) begin
            n_errors = n_errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic start_job(input logic [PW-1:0] pg, input logic [MW-1:0] s,
                             input logic [MW-1:0] d, input logic [FW-1:0] fr);
        phase_open = 1'b1;
        req_page = pg; req_src = s; req_dst = d; req_frame = fr;
        req_valid = 1'b1;
        step();
        req_valid = 1'b0;
        chk("R3 lock_valid after accept", lock_valid, 1);
        chk("R3 lock_page", lock_page, pg);
    endtask

    task automatic lock_and_ack_all();
        lock_ready = 1'b1; step(); lock_ready = 1'b0;
        lock_ack = '1; step(); lock_ack = '0; step();
    endtask

    task automatic finish_job(input logic [FW-1:0] fr);
        move_ready = 1'b1; store_ready = 1'b1; step();
        move_ready = 1'b0; store_ready = 1'b0;
        cmpl_valid = 1'b1; step(); cmpl_valid = 1'b0;
        chk("R8 resume_frame", resume_frame, fr);
        resume_ready = 1'b1; step(); resume_ready = 1'b0;
        chk("R9 done pulse", done, 1);
        step();
        chk("R9 done cleared", done, 0);
    endtask

    task automatic t_reset();
        step(2);
        chk("R1 lock_valid in reset", lock_valid, 0);
        chk("R1 cmd valids in reset", {move_valid, store_valid, resume_valid}, 0);
        chk("R1 done in reset", done, 0);
        rst_n = 1'b1;
        step();
        chk("R1 req_ready closed", req_ready, 0);
        phase_open = 1'b1; #1;
        chk("R1 req_ready open", req_ready, 1);
        phase_open = 1'b0;
    endtask

    task automatic t_phase_gate();
        phase_open = 1'b0; req_valid = 1'b1; req_page = 20'h11111;
        step(3);
        chk("R2 no lock while window closed", lock_valid, 0);
        req_valid = 1'b0;
    endtask

    task automatic t_basic();
        start_job(20'hABCDE, 2'd1, 2'd3, 24'h123456);
        req_valid = 1'b1; req_page = 20'h55555; #1;
        chk("R2 req_ready low while busy", req_ready, 0);
        step(2);
        req_valid = 1'b0;
        chk("R3 lock held", lock_valid, 1);
        chk("R2 busy request not taken", lock_page, 20'hABCDE);
        lock_ready = 1'b1; step(); lock_ready = 1'b0;
        chk("R3 lock dropped after accept", lock_valid, 0);
        lock_ack = '1; step(); lock_ack = '0;
        chk("R4 no move one cycle after last ack", move_valid, 0);
        step();
        chk("R4 move after all acks", move_valid, 1);
        chk("R6 store after all acks", store_valid, 1);
        chk("R6 move_mod", move_mod, 1);
        chk("R6 move_peer", move_peer, 3);
        chk("R6 move_frame", move_frame, 24'h123456);
        chk("R6 store_mod", store_mod, 3);
        chk("R6 store_peer", store_peer, 1);
        chk("R6 store_page", store_page, 20'hABCDE);
        move_ready = 1'b1; step(); move_ready = 1'b0;
        chk("R6 move gone after ready", move_valid, 0);
        chk("R6 store still held", store_valid, 1);
        store_ready = 1'b1; step(); store_ready = 1'b0;
        chk("R6 store gone after ready", store_valid, 0);
        step(2);
        chk("R7 no resume before completion", resume_valid, 0);
        cmpl_valid = 1'b1; step(); cmpl_valid = 1'b0;
        chk("R7 resume after completion", resume_valid, 1);
        chk("R8 resume_page", resume_page, 20'hABCDE);
        chk("R8 resume_frame", resume_frame, 24'h123456);
        step();
        chk("R8 resume held", resume_valid, 1);
        resume_ready = 1'b1; step(); resume_ready = 1'b0;
        chk("R9 done after resume", done, 1);
        chk("R9 resume dropped", resume_valid, 0);
        step();
        chk("R9 done one cycle", done, 0);
        chk("R9 back to idle", req_ready, 1);
    endtask

    task automatic t_dup_acks();
        start_job(20'h0BEEF, 2'd0, 2'd2, 24'h00A0B0);
        lock_ready = 1'b1; step(); lock_ready = 1'b0;
        lock_ack = 4'b0001; step();
        lock_ack = 4'b0001; step();
        lock_ack = 4'b0101; step();
        lock_ack = 4'b0010; step();
        lock_ack = 4'b0100; step();
        lock_ack = '0; step(2);
        chk("R4 duplicates do not complete mask", move_valid, 0);
        lock_ack = 4'b1000; step(); lock_ack = '0; step();
        chk("R4 last module completes mask", move_valid, 1);
        finish_job(24'h00A0B0);
    endtask

    task automatic t_early();
        start_job(20'h7A7A7, 2'd3, 2'd1, 24'hFEDCBA);
        lock_ack = '1; step();
        lock_ack = '1; lock_ready = 1'b1; step();
        lock_ack = '0; lock_ready = 1'b0;
        step(3);
        chk("R5 early acks ignored", move_valid, 0);
        lock_ack = '1; step(); lock_ack = '0; step();
        chk("R5 proper acks advance", store_valid, 1);
        store_ready = 1'b1; cmpl_valid = 1'b1; step();
        store_ready = 1'b0; cmpl_valid = 1'b0;
        chk("R6 move pending after store", move_valid, 1);
        chk("R6 store accepted first", store_valid, 0);
        move_ready = 1'b1; step(); move_ready = 1'b0;
        step(2);
        chk("R7 early completion ignored", resume_valid, 0);
        cmpl_valid = 1'b1; step(); cmpl_valid = 1'b0;
        chk("R7 resume after real completion", resume_valid, 1);
        chk("R8 resume_frame early case", resume_frame, 24'hFEDCBA);
        resume_ready = 1'b1; step(); resume_ready = 1'b0;
        chk("R9 done early case", done, 1);
        step();
    endtask

    task automatic t_second();
        start_job(20'h00042, 2'd2, 2'd0, 24'h000777);
        lock_ready = 1'b1; step(); lock_ready = 1'b0;
        lock_ack = 4'b0111; step(); lock_ack = '0; step(2);
        chk("R10 mask cleared between jobs", move_valid, 0);
        lock_ack = 4'b1000; step(); lock_ack = '0; step();
        chk("R10 second move", move_valid, 1);
        chk("R10 second move_mod", move_mod, 2);
        chk("R10 second store_mod", store_mod, 0);
        chk("R10 second page", move_page, 20'h00042);
        finish_job(24'h000777);
    endtask

    initial begin
        t_reset();
        t_phase_gate();
        t_basic();
        t_dup_acks();
        t_early();
        t_second();
        start_job(20'h00001, 2'd0, 2'd1, 24'h000001);
        lock_and_ack_all();
        chk("R6 both issued quick job", {move_valid, store_valid}, 2'b11);
        finish_job(24'h000001);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule